// File: doc/BRIEF.md
# Strap-addressed I2C target for a 16-bit register space

This block is an I2C target that gives a host access to a register space with 16-bit offsets and 16-bit words. Its 7-bit bus address is not fixed. It is derived from two three-level configuration straps and one stored address-LSB bit, so several identical parts can share one bus. The straps arrive already digitised as 2-bit level codes. The HW/SW strap also picks one of two configuration pages, and that choice appears on its own output.

A host writes by sending the address byte with the write direction, two offset bytes and then two data bytes, all most-significant byte first. The block acknowledges each byte. It raises a one-cycle write strobe toward the register port only after the last data byte has been acknowledged. To read, the host writes the two offset bytes, issues a repeated START with the read direction, and clocks out the word high byte first. The host's NACK ends the read.

SCL and SDA are synchronised and glitch-filtered on the system clock, and SDA is driven only as an open-drain enable. The block stays off the bus after reset and whenever its enable input is low.

Top module: `i2cst_target`

## Requirements
- R1: The first byte after a START carries the address in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). On a match the block pulls SDA low (`sda_oe` = 1) during the ninth SCL clock.
- R2: With the reference strap at mid level (code 01, or the alternate code 11), the address is 0x67 whatever the HW/SW strap holds.
- R3: With the reference strap low (00) or high (10) and the HW/SW strap at mid level (01 or 11), the address is 0x68.
- R4: With the reference strap low or high and the HW/SW strap low or high, the address is binary 110100 followed by `addr_lsb`, which gives 0x68 or 0x69.
- R5: `page_sel` is 1 exactly when the HW/SW strap code is high (10).
- R6: A write is the address byte, the offset high byte, the offset low byte, the data high byte and the data low byte, and each byte is acknowledged. `reg_wr_stb` pulses for one cycle after the ACK clock of the final data byte, with `reg_addr` and `reg_wdata` holding the received offset and word.
- R7: After a write of the offset, a repeated START with the read bit returns `reg_rdata` for that offset, high byte first. The block samples `reg_rdata` when the read address is accepted. On the host's NACK the block releases SDA.
- R8: While `enable` is low the block acknowledges no address and never asserts `sda_oe`.
- R9: On an address mismatch the block NACKs and issues no write strobe. It then ignores all bytes until the next START or STOP.
- R10: SCL and SDA pass through a two-flop synchroniser and a filter. A level must persist for FILT_LEN system clocks before it takes effect, so one-cycle pulses on either line are ignored.
- R11: Transfers work with a 50 MHz system clock at both 100 kHz and 400 kHz SCL rates.
- R12: A write byte beyond the final data byte is NACKed and does not cause a second strobe.
- R13: After reset, `sda_oe` and `reg_wr_stb` are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Makes the interface available when high |
| refsel_code | input | 2 | Reference strap level: 00 low, 01 mid, 10 high, 11 mid |
| hwsw_code | input | 2 | HW/SW strap level, same encoding |
| addr_lsb | input | 1 | Stored address LSB |
| scl_in | input | 1 | Raw SCL |
| sda_in | input | 1 | Raw SDA |
| sda_oe | output | 1 | Pull SDA low when 1 |
| page_sel | output | 1 | Configuration page selected by the HW/SW strap |
| reg_addr | output | 16 | Register offset last written |
| reg_wdata | output | 16 | Write word |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Read word for `reg_addr` |

## Verification
Each line passes through 2 synchroniser flops and then FILT_LEN (3) filter clocks. One more edge register follows, so `sda_oe` changes about 6 to 7 system clocks after the SCL falling edge that calls for it. The bench samples SDA in the middle of the SCL high phase, at least 20 clocks after that change, and changes its own SDA only in the middle of the low phase. `reg_wr_stb` appears about 7 clocks after the final ACK clock falls. A monitor counts every strobe pulse and captures the offset and word with it, and the bench compares these only after the STOP. Address decode and `page_sel` are combinational from the straps, so they are checked a few clocks after the straps change.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

   typedef enum logic [1:0] {
      LVL_LOW     = 2'b00,
      LVL_MID     = 2'b01,
      LVL_HIGH    = 2'b10,
      LVL_MID_ALT = 2'b11
   } lvl_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_IGNORE
   } st_e;

   // both mid encodings carry bit 0 set
   function automatic logic lvl_is_mid(input logic [1:0] code);
      return code[0];
   endfunction

endpackage

// File: rtl/i2cst_addr_dec.sv
module i2cst_addr_dec
   import i2cst_pkg::*;
#(
   parameter logic [6:0] FALLBACK_ADDR = 7'h67,
   parameter logic [6:0] BASE_ADDR     = 7'h68
) (
   input  logic [1:0] refsel_code,
   input  logic [1:0] hwsw_code,
   input  logic       addr_lsb,
   output logic [6:0] dev_addr,
   output logic       page_sel
);

   initial begin
      assert (BASE_ADDR[0] == 1'b0)
         else $error("BASE_ADDR must have bit 0 clear");
   end

   always_comb begin
      if (lvl_is_mid(refsel_code))
         dev_addr = FALLBACK_ADDR;
      else if (lvl_is_mid(hwsw_code))
         dev_addr = BASE_ADDR;
      else
         dev_addr = {BASE_ADDR[6:1], addr_lsb};
   end

   assign page_sel = (hwsw_code == LVL_HIGH);

endmodule

// File: rtl/i2cst_line_filter.sv
module i2cst_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);

   localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (FILT_LEN >= 1)    else $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_out <= 1'b1;
            else        line_out <= sync_out;
         end
      end else begin : g_filt
         logic [CNT_W-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt  <= '0;
               line_out <= 1'b1;
            end else if (sync_out == line_out) begin
               run_cnt <= '0;
            end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
               run_cnt  <= '0;
               line_out <= sync_out;
            end else begin
               run_cnt <= run_cnt + CNT_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/i2cst_engine.sv
module i2cst_engine
   import i2cst_pkg::*;
#(
   parameter int OFF_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [6:0]        dev_addr,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [OFF_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr_stb
);

   localparam int OFF_BYTES  = OFF_W / 8;
   localparam int DATA_BYTES = DATA_W / 8;
   localparam int LAST_BYTE  = OFF_BYTES + DATA_BYTES;
   localparam int IDX_W      = $clog2(LAST_BYTE + 2);
   localparam logic [IDX_W-1:0] IDX_OFF_END  = IDX_W'(OFF_BYTES);
   localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(LAST_BYTE);
   localparam logic [IDX_W-1:0] IDX_DONE     = IDX_W'(LAST_BYTE + 1);

   initial begin
      assert (OFF_W % 8 == 0 && OFF_W >= 16)
         else $error("OFF_W must be a multiple of 8, at least 16");
      assert (DATA_W % 8 == 0 && DATA_W >= 16)
         else $error("DATA_W must be a multiple of 8, at least 16");
   end

   st_e               state;
   logic              scl_q, sda_q;
   logic [3:0]        bit_cnt;
   logic [IDX_W-1:0]  byte_idx;
   logic [7:0]        rx_sh;
   logic              rw;
   logic              mack_ok;
   logic [OFF_W-1:0]  off_sh;
   logic [DATA_W-1:0] dat_sh;
   logic [DATA_W-1:0] tx_word;

   logic scl_rise, scl_fall, start_det, stop_det;

   assign scl_rise  =  scl_f & ~scl_q;
   assign scl_fall  = ~scl_f &  scl_q;
   assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
   assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

   assign sda_oe = (state == ST_ACK) ||
                   (state == ST_TX && !tx_word[DATA_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         scl_q      <= 1'b1;
         sda_q      <= 1'b1;
         bit_cnt    <= '0;
         byte_idx   <= '0;
         rx_sh      <= '0;
         rw         <= 1'b0;
         mack_ok    <= 1'b0;
         off_sh     <= '0;
         dat_sh     <= '0;
         tx_word    <= '0;
         reg_addr   <= '0;
         reg_wdata  <= '0;
         reg_wr_stb <= 1'b0;
      end else begin
         reg_wr_stb <= 1'b0;
         scl_q      <= scl_f;
         sda_q      <= sda_f;
         if (!enable) begin
            state <= ST_IDLE;
         end else if (start_det) begin
            state    <= ST_RX;
            bit_cnt  <= '0;
            byte_idx <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     rx_sh   <= {rx_sh[6:0], sda_f};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     bit_cnt <= '0;
                     if (byte_idx == '0) begin
                        if (rx_sh[7:1] == dev_addr) begin
                           state    <= ST_ACK;
                           rw       <= rx_sh[0];
                           tx_word  <= reg_rdata;
                           byte_idx <= IDX_W'(1);
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else if (!rw && byte_idx <= IDX_LAST) begin
                        state    <= ST_ACK;
                        byte_idx <= byte_idx + IDX_W'(1);
                        if (byte_idx <= IDX_OFF_END)
                           off_sh <= {off_sh[OFF_W-9:0], rx_sh};
                        else
                           dat_sh <= {dat_sh[DATA_W-9:0], rx_sh};
                        if (byte_idx == IDX_OFF_END)
                           reg_addr <= {off_sh[OFF_W-9:0], rx_sh};
                        if (byte_idx == IDX_LAST)
                           reg_wdata <= {dat_sh[DATA_W-9:0], rx_sh};
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state   <= rw ? ST_TX : ST_RX;
                     bit_cnt <= '0;
                     if (!rw && byte_idx == IDX_DONE)
                        reg_wr_stb <= 1'b1;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     tx_word <= {tx_word[DATA_W-2:0], tx_word[DATA_W-1]};
                     if (bit_cnt == 4'd7) begin
                        state   <= ST_MACK;
                        bit_cnt <= '0;
                     end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise)
                     mack_ok <= ~sda_f;
                  else if (scl_fall)
                     state <= mack_ok ? ST_TX : ST_IGNORE;
               end
               default: ;
            endcase
         end
      end
   end

   // R8
   enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !sda_oe);

   // R6
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |=> !reg_wr_stb);

   // R6
   stb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |-> $stable(reg_addr));

   // R1
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !$stable(sda_oe)) |-> !scl_f);

endmodule

// File: rtl/i2cst_target.sv
module i2cst_target
   import i2cst_pkg::*;
#(
   parameter int         OFF_W         = 16,
   parameter int         DATA_W        = 16,
   parameter int         SYNC_STAGES   = 2,
   parameter int         FILT_LEN      = 3,
   parameter logic [6:0] FALLBACK_ADDR = 7'h67,
   parameter logic [6:0] BASE_ADDR     = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        refsel_code,
   input  logic [1:0]        hwsw_code,
   input  logic              addr_lsb,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              page_sel,
   output logic [OFF_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr_stb,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int N_LINES = 2;
   localparam int SCL_IX  = 1;
   localparam int SDA_IX  = 0;

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] filt_lines;
   logic [6:0]         dev_addr;

   assign raw_lines[SCL_IX] = scl_in;
   assign raw_lines[SDA_IX] = sda_in;

   generate
      for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
         i2cst_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
         ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[gi]),
            .line_out (filt_lines[gi])
         );
      end
   endgenerate

   i2cst_addr_dec #(
      .FALLBACK_ADDR (FALLBACK_ADDR),
      .BASE_ADDR     (BASE_ADDR)
   ) u_dec (
      .refsel_code (refsel_code),
      .hwsw_code   (hwsw_code),
      .addr_lsb    (addr_lsb),
      .dev_addr    (dev_addr),
      .page_sel    (page_sel)
   );

   i2cst_engine #(
      .OFF_W  (OFF_W),
      .DATA_W (DATA_W)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .dev_addr   (dev_addr),
      .scl_f      (filt_lines[SCL_IX]),
      .sda_f      (filt_lines[SDA_IX]),
      .reg_rdata  (reg_rdata),
      .sda_oe     (sda_oe),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_wr_stb (reg_wr_stb)
   );

endmodule

// File: tb/sim_i2cst_target.sv
`timescale 1ns/1ps
module sim_i2cst_target;

   typedef struct packed {
      logic [1:0]  rs;
      logic [1:0]  hw;
      logic        lsb;
      logic        en;
      logic [6:0]  ba;
      logic [15:0] off;
      logic [15:0] dat;
      logic        ack;
   } vec_t;

   localparam int NV = 10;
   localparam logic [45:0] VECS [0:NV-1] = '{
      {2'b01, 2'b00, 1'b0, 1'b1, 7'h67, 16'h0012, 16'hBEEF, 1'b1},
      {2'b01, 2'b10, 1'b1, 1'b1, 7'h68, 16'h0034, 16'h1111, 1'b0},
      {2'b00, 2'b01, 1'b1, 1'b1, 7'h68, 16'h0100, 16'h2345, 1'b1},
      {2'b10, 2'b01, 1'b0, 1'b1, 7'h69, 16'h0200, 16'h3333, 1'b0},
      {2'b00, 2'b00, 1'b1, 1'b1, 7'h69, 16'h8001, 16'hC0DE, 1'b1},
      {2'b10, 2'b10, 1'b0, 1'b1, 7'h68, 16'hFFFE, 16'h0F0F, 1'b1},
      {2'b10, 2'b00, 1'b0, 1'b1, 7'h69, 16'h1234, 16'h4444, 1'b0},
      {2'b01, 2'b01, 1'b0, 1'b0, 7'h67, 16'h5555, 16'h5555, 1'b0},
      {2'b11, 2'b00, 1'b1, 1'b1, 7'h67, 16'h7F80, 16'hA5A5, 1'b1},
      {2'b00, 2'b11, 1'b0, 1'b1, 7'h68, 16'h0003, 16'h9999, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  refsel_code = 2'b01;
   logic [1:0]  hwsw_code = 2'b00;
   logic        addr_lsb = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe, page_sel, reg_wr_stb;
   logic [15:0] reg_addr, reg_wdata, reg_rdata;
   logic        sda_bus;

   int n_chk = 0;
   int n_fail = 0;
   int hp = 40;
   bit glitch_en = 1'b0;
   int stb_cnt = 0;
   int oe_viol = 0;
   logic [15:0] cap_addr = '0;
   logic [15:0] cap_data = '0;

   always #10 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_oe;
   assign reg_rdata = reg_addr ^ 16'h5A3C;

   i2cst_target u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .refsel_code (refsel_code),
      .hwsw_code   (hwsw_code),
      .addr_lsb    (addr_lsb),
      .scl_in      (scl_m),
      .sda_in      (sda_bus),
      .sda_oe      (sda_oe),
      .page_sel    (page_sel),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_wr_stb  (reg_wr_stb),
      .reg_rdata   (reg_rdata)
   );

   always @(negedge clk) begin
      if (reg_wr_stb) begin
         stb_cnt  <= stb_cnt + 1;
         cap_addr <= reg_addr;
         cap_data <= reg_wdata;
      end
      if (!enable && sda_oe) oe_viol <= oe_viol + 1;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      wt(hp / 2);
      sda_m = b;
      if (glitch_en) begin
         wt(3);
         scl_m = 1'b1;
         wt(1);
         scl_m = 1'b0;
         wt(hp / 2 - 4);
      end else begin
         wt(hp / 2);
      end
      scl_m = 1'b1;
      if (glitch_en && b) begin
         wt(hp / 2);
         sda_m = 1'b0;
         wt(1);
         sda_m = 1'b1;
         wt(hp / 2 - 1);
      end else begin
         wt(hp);
      end
      scl_m = 1'b0;
   endtask

   task automatic recv_bit(output logic b);
      wt(hp / 2);
      sda_m = 1'b1;
      wt(hp / 2);
      scl_m = 1'b1;
      wt(hp / 2);
      b = sda_bus;
      wt(hp / 2);
      scl_m = 1'b0;
   endtask

   task automatic bus_start();
      wt(hp / 2);
      sda_m = 1'b1;
      wt(hp / 2);
      scl_m = 1'b1;
      wt(hp / 2);
      sda_m = 1'b0;
      wt(hp / 2);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wt(hp / 2);
      sda_m = 1'b0;
      wt(hp / 2);
      scl_m = 1'b1;
      wt(hp / 2);
      sda_m = 1'b1;
      wt(hp);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic ab;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      recv_bit(ab);
      acked = ~ab;
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(x);
         b[i] = x;
      end
      send_bit(~mack);
   endtask

   task automatic do_write(input logic [6:0] ba, input logic [15:0] off, input logic [15:0] dat,
                           output logic a_addr, output int n_ack);
      logic a;
      n_ack = 0;
      bus_start();
      send_byte({ba, 1'b0}, a_addr);
      if (a_addr) begin
         send_byte(off[15:8], a); n_ack += int'(a);
         send_byte(off[7:0],  a); n_ack += int'(a);
         send_byte(dat[15:8], a); n_ack += int'(a);
         send_byte(dat[7:0],  a); n_ack += int'(a);
      end
      bus_stop();
   endtask

   task automatic do_read(input logic [6:0] ba, input logic [15:0] off,
                          output logic [15:0] val, output int n_ack);
      logic a;
      n_ack = 0;
      bus_start();
      send_byte({ba, 1'b0}, a); n_ack += int'(a);
      send_byte(off[15:8], a);  n_ack += int'(a);
      send_byte(off[7:0], a);   n_ack += int'(a);
      bus_start();
      send_byte({ba, 1'b1}, a); n_ack += int'(a);
      recv_byte(val[15:8], 1'b1);
      recv_byte(val[7:0], 1'b0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      vec_t v;
      logic a0, ax;
      int na, s0;
      logic [15:0] rv;

      wt(5);
      // R13 reset state
      chk("R13 sda_oe in reset", 32'(sda_oe), 32'd0);
      rst_n = 1'b1;
      wt(3);
      chk("R13 sda_oe after reset", 32'(sda_oe), 32'd0);
      chk("R13 reg_wr_stb after reset", 32'(reg_wr_stb), 32'd0);
      chk("R13 reg_addr after reset", 32'(reg_addr), 32'd0);

      // R8 unavailable after reset until enabled
      do_write(7'h67, 16'h0001, 16'h0002, a0, na);
      chk("R8 no ACK before enable", 32'(a0), 32'd0);
      enable = 1'b1;
      wt(10);

      // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         v = vec_t'(VECS[i]);
         refsel_code = v.rs;
         hwsw_code   = v.hw;
         addr_lsb    = v.lsb;
         enable      = v.en;
         wt(10);
         chk($sformatf("R5 page_sel vec%0d", i), 32'(page_sel), 32'(v.hw == 2'b10));
         s0 = stb_cnt;
         if (v.ack) begin
            do_write(v.ba, v.off, v.dat, a0, na);
            chk($sformatf("R1 R2 R3 R4 address ACK vec%0d", i), 32'(a0), 32'd1);
            chk($sformatf("R6 data bytes ACKed vec%0d", i), 32'(na), 32'd4);
            wt(4);
            chk($sformatf("R6 one strobe vec%0d", i), 32'(stb_cnt - s0), 32'd1);
            chk($sformatf("R6 strobe offset vec%0d", i), 32'(cap_addr), 32'(v.off));
            chk($sformatf("R6 strobe word vec%0d", i), 32'(cap_data), 32'(v.dat));
            do_read(v.ba, v.off, rv, na);
            chk($sformatf("R7 read ACKs vec%0d", i), 32'(na), 32'd4);
            chk($sformatf("R7 read word vec%0d", i), 32'(rv), 32'(v.off ^ 16'h5A3C));
            chk($sformatf("R7 SDA released vec%0d", i), 32'(sda_oe), 32'd0);
         end else begin
            // R9 mismatch, then a following byte must be ignored
            bus_start();
            send_byte({v.ba, 1'b0}, a0);
            chk($sformatf("R9 R8 address NACK vec%0d", i), 32'(a0), 32'd0);
            send_byte(8'h00, ax);
            chk($sformatf("R9 later byte ignored vec%0d", i), 32'(ax), 32'd0);
            bus_stop();
            wt(4);
            chk($sformatf("R9 no strobe vec%0d", i), 32'(stb_cnt - s0), 32'd0);
         end
      end
      enable = 1'b1;
      chk("R8 sda_oe never set while disabled", 32'(oe_viol), 32'd0);

      // R12 extra byte
      refsel_code = 2'b00; hwsw_code = 2'b01; addr_lsb = 1'b0;
      wt(10);
      s0 = stb_cnt;
      bus_start();
      send_byte({7'h68, 1'b0}, a0);
      send_byte(8'h00, ax); send_byte(8'h44, ax);
      send_byte(8'h12, ax); send_byte(8'h34, ax);
      send_byte(8'hFF, ax);
      chk("R12 extra byte NACKed", 32'(ax), 32'd0);
      bus_stop();
      wt(4);
      chk("R12 single strobe", 32'(stb_cnt - s0), 32'd1);
      chk("R12 word kept", 32'(cap_data), 32'h1234);

      // R10 glitches on SCL and SDA during a write
      glitch_en = 1'b1;
      s0 = stb_cnt;
      do_write(7'h68, 16'h0A0B, 16'hF00D, a0, na);
      glitch_en = 1'b0;
      wt(4);
      chk("R10 glitch write ACKs", 32'(na), 32'd4);
      chk("R10 glitch strobe", 32'(stb_cnt - s0), 32'd1);
      chk("R10 glitch offset", 32'(cap_addr), 32'h0A0B);
      chk("R10 glitch word", 32'(cap_data), 32'hF00D);

      // R11 fast mode (400 kHz: 125 clocks per bit) full read
      hp = 62;
      do_read(7'h68, 16'h0C0D, rv, na);
      chk("R11 fast mode read", 32'(rv), 32'(16'h0C0D ^ 16'h5A3C));
      // R11 standard mode (100 kHz: 500 clocks per bit) write
      hp = 250;
      s0 = stb_cnt;
      do_write(7'h68, 16'h2222, 16'h7777, a0, na);
      wt(4);
      chk("R11 standard mode ACKs", 32'(na), 32'd4);
      chk("R11 standard mode word", 32'(cap_data), 32'h7777);
      chk("R11 standard mode strobe", 32'(stb_cnt - s0), 32'd1);

      summary();
      $finish;
   end

endmodule